// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the software-visible register layer that sits in front of a bank of DMA transfer engines. A single 32-bit, word-only access port reaches every channel's registers. The block decodes each access into a channel and a register. For every channel it keeps the control/status word and the control-block address, and it keeps one global channel-enable word and one global interrupt-status word. Each channel has its own interrupt line. The transfer engines run outside this block.

A channel's engine gets a one-cycle start pulse when software turns its active bit from 0 to 1. Each engine reports back with a completion event and an interrupt event. The engines' working copies of the current control block (info, source, destination, length, stride, next block) come in as flat input buses and are read back through the same port. Channels 0 to NCH-2 sit in a low window. There, address bits [11:8] select the channel and bits [7:0] select the register. The last channel is reached through a separate window that is selected by a strobe and uses the same register offsets. The two global words sit at the top of the low window.

Top module: `dma_fe_top`

## Requirements
- R1: After reset every status word and control-block address reads 0, the interrupt-status word reads 0, no interrupt line is high, and the enable word reads 0x0000FFFF.
- R2: A status write replaces only the bits in mask 0x30FF0001. Bits 1, 2, 4, 5 and 8 are never set by a write, and bit 30 has no effect.
- R3: `eng_start` pulses for exactly one cycle, for the written channel only, when a status write moves bit 0 (active) from 0 to 1. A write that leaves it at 1 gives no pulse.
- R4: A completion event clears active (bit 0) and sets end (bit 1) and paused (bit 4). An interrupt event sets status bit 2, the channel's interrupt-status bit and its interrupt line, all on the same edge.
- R5: Writing 1 to status bit 1 clears end. Writing 1 to status bit 2 clears bit 2, the channel's interrupt-status bit and its interrupt line.
- R6: A status write with bit 31 set first clears the whole status word and the control-block address, and then applies the rest of the write. The start decision uses the active bit from before the write.
- R7: In the low window (address < 0xF00, channel = bits [11:8] < NCH-1) and in the last-channel window, offset 0x00 is status and 0x04 is the control-block address. The control-block address of every channel drives `cb_addr`.
- R8: Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read the engine copies of info, source, destination, length, stride and next block. Writes to them change nothing and raise the error flag.
- R9: Address 0xFE0 reads the interrupt-status word, and writes to it are ignored without error. Address 0xFF0 is the enable word: a write stores its low NCH bits, which drive `chan_en`.
- R10: An access to any undefined or unaligned address reads 0, changes nothing, and raises `bus_err` for one cycle only.
- R11: Read data appears on `bus_rdata` on the edge that samples the read and holds until the next read.
- R12: Offset 0x20 is a per-channel debug word that is written and read back unchanged, with no cross-channel effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_hi | input | 1 | Selects the last-channel window |
| bus_addr | input | 12 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle flag for a bad access |
| eng_start | output | NCH | Start pulse per channel |
| eng_done | input | NCH | Completion event per channel |
| eng_irq | input | NCH | Interrupt event per channel |
| chan_en | output | NCH | Global enable bits |
| irq | output | NCH | Interrupt line per channel |
| cb_addr | output | NCH*32 | Control-block address of each channel |
| cb_info | input | NCH*32 | Engine copy of info |
| cb_src | input | NCH*32 | Engine copy of source address |
| cb_dst | input | NCH*32 | Engine copy of destination address |
| cb_len | input | NCH*32 | Engine copy of length |
| cb_stride | input | NCH*32 | Engine copy of stride |
| cb_next | input | NCH*32 | Engine copy of next block address |

## Verification
Every result is due one edge after its stimulus. Read data and the error flag follow the edge that samples the access. Start pulses, status and enable changes and interrupt lines follow the edge that samples the write or the engine event. The bench drives inputs on falling edges and updates a behavioural model on the same rising edge as the design. It then compares all outputs on the next falling edge, so each result is examined in the first cycle in which it is due. Directed reads and one-cycle-later checks confirm the one-cycle pulse width and that no extra register is left stale.

// File: rtl/dma_fe_pkg.sv
package dma_fe_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  // status word bit positions
  localparam int unsigned ST_ACT   = 0;
  localparam int unsigned ST_END   = 1;
  localparam int unsigned ST_INT   = 2;
  localparam int unsigned ST_PAUSE = 4;
  localparam int unsigned ST_RESET = 31;
  localparam logic [DATA_W-1:0] ST_RW_MASK = 32'h30FF_0001;

  // per-channel offsets
  localparam logic [7:0] OFF_CS   = 8'h00;
  localparam logic [7:0] OFF_CBA  = 8'h04;
  localparam logic [7:0] OFF_INFO = 8'h08;
  localparam logic [7:0] OFF_SRC  = 8'h0C;
  localparam logic [7:0] OFF_DST  = 8'h10;
  localparam logic [7:0] OFF_LEN  = 8'h14;
  localparam logic [7:0] OFF_STR  = 8'h18;
  localparam logic [7:0] OFF_NXT  = 8'h1C;
  localparam logic [7:0] OFF_DBG  = 8'h20;

  localparam logic [ADDR_W-1:0] GLB_BASE = 12'hF00;
  localparam logic [ADDR_W-1:0] GLB_IST  = 12'hFE0;
  localparam logic [ADDR_W-1:0] GLB_EN   = 12'hFF0;

  typedef enum logic [3:0] {
    SEL_CS, SEL_CBA, SEL_INFO, SEL_SRC, SEL_DST, SEL_LEN,
    SEL_STRIDE, SEL_NEXT, SEL_DBG, SEL_IST, SEL_EN, SEL_NONE
  } fe_sel_e;
endpackage

// File: rtl/dma_fe_decode.sv
module dma_fe_decode
  import dma_fe_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CW  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              hi,
  output fe_sel_e           sel,
  output logic [CW-1:0]     chan
);
  logic [3:0] raw_ch;
  logic [7:0] off;
  logic       perchan;

  always_comb begin
    raw_ch  = addr[11:8];
    off     = addr[7:0];
    perchan = 1'b0;
    chan    = '0;
    sel     = SEL_NONE;
    if (hi) begin
      perchan = 1'b1;
      chan    = CW'(NCH - 1);
    end else if (addr < GLB_BASE && raw_ch < 4'(NCH - 1)) begin
      perchan = 1'b1;
      chan    = raw_ch[CW-1:0];
    end
    if (perchan) begin
      case (off)
        OFF_CS:   sel = SEL_CS;
        OFF_CBA:  sel = SEL_CBA;
        OFF_INFO: sel = SEL_INFO;
        OFF_SRC:  sel = SEL_SRC;
        OFF_DST:  sel = SEL_DST;
        OFF_LEN:  sel = SEL_LEN;
        OFF_STR:  sel = SEL_STRIDE;
        OFF_NXT:  sel = SEL_NEXT;
        OFF_DBG:  sel = SEL_DBG;
        default:  sel = SEL_NONE;
      endcase
    end else if (addr == GLB_IST) begin
      sel = SEL_IST;
    end else if (addr == GLB_EN) begin
      sel = SEL_EN;
    end
  end
endmodule

// File: rtl/dma_fe_chan.sv
module dma_fe_chan
  import dma_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cs,
  input  logic              wr_cba,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done_ev,
  input  logic              irq_ev,
  output logic [DATA_W-1:0] cs_q,
  output logic [DATA_W-1:0] cba_q,
  output logic              int_q,
  output logic              start_q
);
  logic [DATA_W-1:0] cs_n, cba_n;
  logic              int_n, go;

  always_comb begin
    cs_n  = cs_q;
    cba_n = cba_q;
    int_n = int_q;
    go    = 1'b0;
    if (wr_cs) begin
      if (wdata[ST_RESET]) begin
        cs_n  = '0;
        cba_n = '0;
      end
      if (wdata[ST_END]) cs_n[ST_END] = 1'b0;
      if (wdata[ST_INT]) begin
        cs_n[ST_INT] = 1'b0;
        int_n        = 1'b0;
      end
      cs_n = (cs_n & ~ST_RW_MASK) | (wdata & ST_RW_MASK);
      go   = !cs_q[ST_ACT] && cs_n[ST_ACT];
    end else if (wr_cba) begin
      cba_n = wdata;
    end
    // engine events win over a clearing write on the same edge
    if (done_ev) begin
      cs_n[ST_ACT]   = 1'b0;
      cs_n[ST_END]   = 1'b1;
      cs_n[ST_PAUSE] = 1'b1;
    end
    if (irq_ev) begin
      cs_n[ST_INT] = 1'b1;
      int_n        = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= '0;
      cba_q   <= '0;
      int_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cs_q    <= cs_n;
      cba_q   <= cba_n;
      int_q   <= int_n;
      start_q <= go;
    end
  end

  // R3
  start_edge_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |-> ($past(wr_cs) && !$past(cs_q[ST_ACT])));
  // R4
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ev |=> (int_q && cs_q[ST_INT]));
  // R5
  int_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cs && wdata[ST_INT] && !irq_ev) |=> !int_q);
  // R6
  rst_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cs && wdata[ST_RESET]) |=> (cba_q == '0));
endmodule

// File: rtl/dma_fe_top.sv
module dma_fe_top
  import dma_fe_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic                bus_hi,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_err,
  output logic [NCH-1:0]      eng_start,
  input  logic [NCH-1:0]      eng_done,
  input  logic [NCH-1:0]      eng_irq,
  output logic [NCH-1:0]      chan_en,
  output logic [NCH-1:0]      irq,
  output logic [NCH*32-1:0]   cb_addr,
  input  logic [NCH*32-1:0]   cb_info,
  input  logic [NCH*32-1:0]   cb_src,
  input  logic [NCH*32-1:0]   cb_dst,
  input  logic [NCH*32-1:0]   cb_len,
  input  logic [NCH*32-1:0]   cb_stride,
  input  logic [NCH*32-1:0]   cb_next
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  fe_sel_e           sel_d;
  logic [CW-1:0]     ch_d;
  logic              wr, rd, ro_hit;
  logic [DATA_W-1:0] cs_a  [NCH];
  logic [DATA_W-1:0] cba_a [NCH];
  logic [DATA_W-1:0] dbg_mem [NCH];
  logic [NCH-1:0]    int_v, start_v, en_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  dma_fe_decode #(.NCH(NCH), .CW(CW)) u_dec (
    .addr(bus_addr), .hi(bus_hi), .sel(sel_d), .chan(ch_d)
  );

  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_fe_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_cs   (wr && sel_d == SEL_CS  && ch_d == CW'(c)),
      .wr_cba  (wr && sel_d == SEL_CBA && ch_d == CW'(c)),
      .wdata   (bus_wdata),
      .done_ev (eng_done[c]),
      .irq_ev  (eng_irq[c]),
      .cs_q    (cs_a[c]),
      .cba_q   (cba_a[c]),
      .int_q   (int_v[c]),
      .start_q (start_v[c])
    );
    assign cb_addr[c*32 +: 32] = cba_a[c];
  end

  // debug words: plain RAM, no reset, registered read
  always_ff @(posedge clk) begin
    if (wr && sel_d == SEL_DBG) dbg_mem[ch_d] <= bus_wdata;
  end

  always_comb begin
    case (sel_d)
      SEL_CS:     rd_mux = cs_a[ch_d];
      SEL_CBA:    rd_mux = cba_a[ch_d];
      SEL_INFO:   rd_mux = cb_info[{ch_d, 5'd0} +: 32];
      SEL_SRC:    rd_mux = cb_src[{ch_d, 5'd0} +: 32];
      SEL_DST:    rd_mux = cb_dst[{ch_d, 5'd0} +: 32];
      SEL_LEN:    rd_mux = cb_len[{ch_d, 5'd0} +: 32];
      SEL_STRIDE: rd_mux = cb_stride[{ch_d, 5'd0} +: 32];
      SEL_NEXT:   rd_mux = cb_next[{ch_d, 5'd0} +: 32];
      SEL_IST:    rd_mux = 32'(int_v);
      SEL_EN:     rd_mux = 32'(en_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rd) rdata_q <= (sel_d == SEL_DBG) ? dbg_mem[ch_d] : rd_mux;
  end

  assign ro_hit = (sel_d inside {SEL_INFO, SEL_SRC, SEL_DST, SEL_LEN, SEL_STRIDE, SEL_NEXT});

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '1;
      err_q <= 1'b0;
    end else begin
      err_q <= bus_sel && (sel_d == SEL_NONE || (bus_we && ro_hit));
      if (wr && sel_d == SEL_EN) en_q <= bus_wdata[NCH-1:0];
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign eng_start = start_v;
  assign irq       = int_v;
  assign chan_en   = en_q;

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel));
  // R1
  en_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (chan_en == {NCH{1'b1}}));
  // R9
  ist_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && sel_d == SEL_IST && eng_irq == '0) |=> $stable(irq));
  // R3
  start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(eng_start));
endmodule

// File: tb/test_dma_fe_top.sv
module test_dma_fe_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0, bus_hi = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [N-1:0] eng_start, chan_en, irq;
  logic [N-1:0] eng_done = '0, eng_irq = '0;
  logic [N*32-1:0] cb_addr;
  logic [N*32-1:0] cb_info, cb_src, cb_dst, cb_len, cb_stride, cb_next;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_fe_top #(.NCH(N)) i_dma_fe_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_hi(bus_hi),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .eng_start(eng_start), .eng_done(eng_done),
    .eng_irq(eng_irq), .chan_en(chan_en), .irq(irq), .cb_addr(cb_addr),
    .cb_info(cb_info), .cb_src(cb_src), .cb_dst(cb_dst), .cb_len(cb_len),
    .cb_stride(cb_stride), .cb_next(cb_next)
  );

  function automatic logic [31:0] cpv(input int k, input int c);
    return {8'(16 + k), 8'h00, 8'(c), 8'(k)};
  endfunction

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cs [N];
  logic [31:0] m_cba [N];
  logic [31:0] m_dbg [N];
  logic [15:0] m_ist, m_en, m_start;
  logic [31:0] m_rdata;
  logic m_err, m_rdv;

  always @(posedge clk) begin
    int s, c;
    logic pc;
    logic [31:0] old, w;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_cs[i] = 0; m_cba[i] = 0; end
      m_ist = 0; m_en = 16'hFFFF; m_start = 0; m_err = 0; m_rdv = 0;
    end else begin
      m_start = 0; m_err = 0; m_rdv = 0;
      if (bus_sel) begin
        pc = 0; c = 0; s = 11;
        if (bus_hi) begin pc = 1; c = N - 1; end
        else if (bus_addr < 12'hF00 && int'(bus_addr[11:8]) < N - 1) begin
          pc = 1; c = int'(bus_addr[11:8]);
        end
        if (pc) begin
          if (bus_addr[7:0] <= 8'h20 && bus_addr[1:0] == 2'b00) s = int'(bus_addr[7:2]);
        end else if (bus_addr == 12'hFE0) s = 9;
        else if (bus_addr == 12'hFF0) s = 10;
        w = bus_wdata;
        if (!bus_we) begin
          m_rdv = 1;
          case (s)
            0: m_rdata = m_cs[c];
            1: m_rdata = m_cba[c];
            2, 3, 4, 5, 6, 7: m_rdata = cpv(s - 2, c);
            8: m_rdata = m_dbg[c];
            9: m_rdata = {16'h0, m_ist};
            10: m_rdata = {16'h0, m_en};
            default: begin m_rdata = 0; m_err = 1; end
          endcase
        end else begin
          case (s)
            0: begin
              old = m_cs[c];
              if (w[31]) begin m_cs[c] = 0; m_cba[c] = 0; end
              if (w[1]) m_cs[c][1] = 0;
              if (w[2]) begin m_cs[c][2] = 0; m_ist[c] = 0; end
              m_cs[c] = (m_cs[c] & ~32'h30FF0001) | (w & 32'h30FF0001);
              if (!old[0] && m_cs[c][0]) m_start[c] = 1;
            end
            1: m_cba[c] = w;
            8: m_dbg[c] = w;
            9: ;
            10: m_en = w[15:0];
            default: m_err = 1;
          endcase
        end
      end
      for (int i = 0; i < N; i++) begin
        if (eng_done[i]) begin m_cs[i][0] = 0; m_cs[i][1] = 1; m_cs[i][4] = 1; end
        if (eng_irq[i]) begin m_cs[i][2] = 1; m_ist[i] = 1; end
      end
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      cmp("R3 eng_start", 32'(eng_start), 32'(m_start));
      cmp("R4 irq lines", 32'(irq), 32'(m_ist));
      cmp("R9 chan_en", 32'(chan_en), 32'(m_en));
      cmp("R10 bus_err", 32'(bus_err), 32'(m_err));
      if (m_rdv) cmp("R11 bus_rdata", bus_rdata, m_rdata);
      for (int i = 0; i < N; i++) cmp("R7 cb_addr", cb_addr[i*32 +: 32], m_cba[i]);
    end
  end

  // ---------------- stimulus tasks (start and end at a falling edge) ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic h = 1'b0);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_hi = h;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_hi = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e,
                    input logic h = 1'b0);
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_hi = h;
    @(negedge clk);
    bus_sel = 0; bus_hi = 0;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic ev(input int c, input logic with_irq);
    eng_done[c] = 1; eng_irq[c] = with_irq;
    @(negedge clk);
    eng_done = '0; eng_irq = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    for (int c = 0; c < N; c++) begin
      cb_info[c*32 +: 32]   = cpv(0, c);
      cb_src[c*32 +: 32]    = cpv(1, c);
      cb_dst[c*32 +: 32]    = cpv(2, c);
      cb_len[c*32 +: 32]    = cpv(3, c);
      cb_stride[c*32 +: 32] = cpv(4, c);
      cb_next[c*32 +: 32]   = cpv(5, c);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rd(12'h000, d, e); cmp("R1 status after reset", d, 0);
    rd(12'h004, d, e); cmp("R1 cb address after reset", d, 0);
    rd(12'hFF0, d, e); cmp("R1 enable after reset", d, 32'h0000FFFF);
    rd(12'hFE0, d, e); cmp("R1 int status after reset", d, 0);
    cmp("R1 irq after reset", 32'(irq), 0);

    // R2 masked status write
    wr(12'h200, 32'h3FAB_0136);
    cmp("R2 no start on masked write", 32'(eng_start), 0);
    rd(12'h200, d, e); cmp("R2 masked status", d, 32'h30AB_0000);

    // R7 control-block address
    wr(12'h304, 32'h1234_5670);
    rd(12'h304, d, e); cmp("R7 cb address ch3", d, 32'h1234_5670);
    cmp("R7 cb_addr port ch3", cb_addr[3*32 +: 32], 32'h1234_5670);
    rd(12'h204, d, e); cmp("R7 ch2 untouched", d, 0);

    // R3 start on rising active
    wr(12'h300, 32'h1);
    cmp("R3 start pulse ch3", 32'(eng_start), 32'h0008);
    @(negedge clk);
    cmp("R3 pulse one cycle", 32'(eng_start), 0);
    wr(12'h300, 32'h1);
    cmp("R3 no restart while active", 32'(eng_start), 0);

    // R4 completion with interrupt
    ev(3, 1'b1);
    cmp("R4 irq line ch3", 32'(irq), 32'h0008);
    rd(12'h300, d, e); cmp("R4 status after done", d, 32'h0000_0016);
    rd(12'hFE0, d, e); cmp("R4 int status word", d, 32'h8);

    // R5 write-one-to-clear
    wr(12'h300, 32'h2);
    cmp("R5 irq stays after end clear", 32'(irq), 32'h0008);
    rd(12'h300, d, e); cmp("R5 end cleared", d, 32'h14);
    wr(12'h300, 32'h4);
    cmp("R5 irq cleared", 32'(irq), 0);
    rd(12'h300, d, e); cmp("R5 int bit cleared", d, 32'h10);
    rd(12'hFE0, d, e); cmp("R5 int status cleared", d, 0);
    ev(3, 1'b0);
    cmp("R4 done without irq", 32'(irq), 0);
    rd(12'h300, d, e); cmp("R4 end set, no int", d, 32'h12);

    // R6 channel reset bit
    wr(12'h300, 32'h1);
    cmp("R6 start before reset test", 32'(eng_start), 32'h0008);
    wr(12'h304, 32'hABCD_0000);
    wr(12'h300, 32'h8000_0001);
    cmp("R6 no start when active was set", 32'(eng_start), 0);
    rd(12'h300, d, e); cmp("R6 status after reset bit", d, 32'h1);
    rd(12'h304, d, e); cmp("R6 cb address cleared", d, 0);

    // R7 last-channel window
    wr(12'h004, 32'hCAFE_0000, 1'b1);
    rd(12'h004, d, e, 1'b1); cmp("R7 hi window cb address", d, 32'hCAFE_0000);
    cmp("R7 cb_addr port ch15", cb_addr[15*32 +: 32], 32'hCAFE_0000);
    rd(12'h104, d, e); cmp("R7 ch1 untouched", d, 0);
    wr(12'h000, 32'h1, 1'b1);
    cmp("R3 start via hi window", 32'(eng_start), 32'h8000);
    rd(12'hF04, d, e);
    cmp("R10 low window ch15 slot reads zero", d, 0);
    cmp("R10 low window ch15 slot error", 32'(e), 1);

    // R8 read-only engine copies
    rd(12'h508, d, e); cmp("R8 info ch5", d, 32'h1000_0500);
    rd(12'h514, d, e); cmp("R8 length ch5", d, 32'h1300_0503);
    cmp("R8 no error on read", 32'(e), 0);
    wr(12'h508, 32'hFFFF_FFFF);
    cmp("R8 error on write", 32'(bus_err), 1);
    rd(12'h508, d, e); cmp("R8 info unchanged", d, 32'h1000_0500);

    // R9 global words
    ev(6, 1'b1);
    wr(12'hFE0, 32'h0);
    cmp("R9 no error on status write", 32'(bus_err), 0);
    cmp("R9 irq unchanged", 32'(irq), 32'h0040);
    rd(12'hFE0, d, e); cmp("R9 int status kept", d, 32'h40);
    wr(12'hFF0, 32'hFFFF_00A5);
    cmp("R9 chan_en", 32'(chan_en), 32'h00A5);
    rd(12'hFF0, d, e); cmp("R9 enable readback", d, 32'hA5);

    // R10 undefined offsets
    rd(12'h224, d, e);
    cmp("R10 undefined reads zero", d, 0);
    cmp("R10 error raised", 32'(e), 1);
    @(negedge clk);
    cmp("R10 error one cycle", 32'(bus_err), 0);
    rd(12'h202, d, e); cmp("R10 unaligned error", 32'(e), 1);
    wr(12'h224, 32'hFFFF_FFFF);
    rd(12'h200, d, e); cmp("R10 write had no effect", d, 32'h30AB_0000);

    // R12 debug word
    wr(12'h120, 32'hDEAD_BEEF);
    wr(12'h720, 32'h0BAD_F00D);
    rd(12'h120, d, e); cmp("R12 debug ch1", d, 32'hDEAD_BEEF);
    rd(12'h720, d, e); cmp("R12 debug ch7", d, 32'h0BAD_F00D);

    // R11 read data holds across writes and idle cycles
    wr(12'h304, 32'h5555_0000);
    @(negedge clk);
    cmp("R11 rdata holds", bus_rdata, 32'h0BAD_F00D);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule